// File: doc/BRIEF.md
# Presettable Synchronous Up-Counter with Dual Count Enables

This block is a small synchronous up-counter. Its state register takes a new value only on the rising clock edge, and all of its bits change together. A parallel word can be preset into it. It counts up only when both of its count enables are high. One build parameter picks the modulus: decade (0 to 9) or full binary (0 to 15 at the default width). A second build parameter picks how the active-low clear acts. It can act at once, with no clock, or it can act on the next rising edge.

The carry output is high while the count sits at its terminal value and the carry-gating enable is high. That enable reaches the carry output through logic only, with no register in the path. Several counters can therefore be chained through this pair of signals. On each edge the operation is one of four named operations, taken in this order of priority: OP_CLEAR (only in the clocked-clear build), OP_LOAD, OP_COUNT and OP_HOLD. The operation comes only from the control levels present at that edge.

Top module: `preset_counter`

## Requirements
- R1: The count changes only on a rising clock edge, with all bits together. The one exception is the immediate clear of R5. Changing load_n, din, en_p or en_t between edges leaves q unchanged.
- R2: When load_n is low at a rising edge and no clear acts, q equals din after that edge, whatever en_p and en_t are.
- R3: When load_n is high and both en_p and en_t are high at a rising edge, q advances by one.
- R4: When load_n is high and en_p or en_t is low at a rising edge, q keeps its value.
- R5: With ASYNC_CLEAR=1, a low clr_n forces q to 0 at once and holds it at 0, whatever the clock, load and enables do.
- R6: With ASYNC_CLEAR=0, a low clr_n at a rising edge sets q to 0 at that edge.
- R7: carry_out is high exactly when en_t is high and q equals the terminal value. The terminal value is 9 when DECADE=1 and all ones when DECADE=0. carry_out follows en_t without waiting for a clock edge.
- R8: A count step from the terminal value gives 0. That is 9 to 0 in decade mode and 15 to 0 in binary mode.
- R9: In decade mode, a loaded value from 10 to 15 counts up by one per step, and 15 wraps to 0. carry_out stays low for all of these values.
- R10: When several controls are active at one edge, the order of priority is clear, then load, then count, then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state is taken on the rising edge |
| clr_n | input | 1 | Active-low clear; acts at once or on the edge, as ASYNC_CLEAR sets |
| load_n | input | 1 | Active-low parallel preset |
| din | input | WIDTH | Preset word, bit 0 is least significant |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates carry_out |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count carry, gated by en_t |

## Verification
The clocked properties are switched off while clr_n is low. They therefore assume that the first clear comes before any load or count, so that the state is known. The bench holds clr_n low across the first two edges before it drives anything else. The bench changes every control only at the falling edge, so the levels seen at each rising edge are settled. Random clears, loads and enable patterns are mixed with directed presets near the wrap points. The same stimulus drives all four builds (decade or binary, immediate or clocked clear) at once, and each build is compared with its own expected value.

// File: rtl/preset_counter_pkg.sv
package preset_counter_pkg;
    // operation applied at a rising edge, listed in priority order
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/preset_counter_op_select.sv
module preset_counter_op_select
    import preset_counter_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);
    // clear outranks load, load outranks count, count outranks hold
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/preset_counter_next.sv
module preset_counter_next
    import preset_counter_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b1
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : '1;

    logic [WIDTH-1:0] incr;

    generate
        if (DECADE) begin : g_dec
            // only the terminal value folds back early; 10..15 run on
            assign incr = (q == TERM) ? '0 : q + WIDTH'(1);
        end else begin : g_bin
            assign incr = q + WIDTH'(1);
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = incr;
            OP_HOLD:  nxt = q;
            default:  nxt = q;
        endcase
    end
endmodule

// File: rtl/preset_counter_carry.sv
module preset_counter_carry #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : '1;

    logic at_term;

    always_comb begin
        at_term   = (q == TERM);
        carry_out = at_term & en_t;
    end
endmodule

// File: rtl/preset_counter.sv
module preset_counter
    import preset_counter_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit DECADE      = 1'b1,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);
    cnt_op_e          op;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] cnt_q;

    preset_counter_op_select u_op (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    preset_counter_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
        .op  (op),
        .q   (cnt_q),
        .din (din),
        .nxt (nxt)
    );

    // state register: the clear style picks the sensitivity list
    generate
        if (ASYNC_CLEAR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    cnt_q <= '0;
                else
                    cnt_q <= nxt;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                cnt_q <= nxt;
            end
        end
    endgenerate

    preset_counter_carry #(.WIDTH(WIDTH), .DECADE(DECADE)) u_carry (
        .q         (cnt_q),
        .en_t      (en_t),
        .carry_out (carry_out)
    );

    assign q = cnt_q;
endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk #(
    parameter int WIDTH       = 4,
    parameter bit DECADE      = 1'b1,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);
    localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : '1;

    // R2
    load_data_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && !load_n) |=> (q == $past(din)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && q != TERM) |=> (q == $past(q) + WIDTH'(1)));

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && q == TERM) |=> (q == '0));

    // R4
    hold_value_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(q));

    // R7
    carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !en_t |-> !carry_out);

    // R7
    carry_term_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (q == TERM));

    generate
        if (ASYNC_CLEAR) begin : g_async
            // R5
            clear_async_chk: assert property (@(posedge clk)
                !clr_n |-> (q == '0));
        end else begin : g_sync
            // R6
            clear_sync_chk: assert property (@(posedge clk)
                !clr_n |=> (q == '0));
        end
    endgenerate
endmodule

bind preset_counter preset_counter_chk #(
    .WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_CLEAR(ASYNC_CLEAR)
) u_chk (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q), .carry_out(carry_out)
);

// File: tb/test_preset_counter.sv
module test_preset_counter;
    localparam int CLK_PERIOD = 10;

    logic       clk    = 1'b0;
    logic       clr_n  = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] din    = 4'd0;
    logic       en_p   = 1'b0;
    logic       en_t   = 1'b0;

    logic [3:0] q0, q1, q2, q3;
    logic       c0, c1, c2, c3;

    int checks = 0;
    int errors = 0;
    int expq [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    // variant 0: decade/immediate clear, 1: binary/immediate, 2: decade/clocked, 3: binary/clocked
    preset_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLEAR(1'b1)) i_preset_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q0), .carry_out(c0));
    preset_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLEAR(1'b1)) i_preset_counter_bin_async (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q1), .carry_out(c1));
    preset_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLEAR(1'b0)) i_preset_counter_dec_sync (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q2), .carry_out(c2));
    preset_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLEAR(1'b0)) i_preset_counter_bin_sync (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q3), .carry_out(c3));

    function automatic bit is_dec(int v);   return (v % 2) == 0; endfunction
    function automatic bit is_async(int v); return v < 2;        endfunction
    function automatic int term_of(int v);  return is_dec(v) ? 9 : 15; endfunction

    function automatic int get_q(int v);
        case (v)
            0: return int'(q0);
            1: return int'(q1);
            2: return int'(q2);
            default: return int'(q3);
        endcase
    endfunction

    function automatic int get_c(int v);
        case (v)
            0: return int'(c0);
            1: return int'(c1);
            2: return int'(c2);
            default: return int'(c3);
        endcase
    endfunction

    // expected next count from the requirement priorities (R10)
    function automatic int model_next(int v, int cur, bit c, bit l, int d, bit p, bit t);
        if (!c) return 0;
        if (!l) return d;
        if (p && t) begin
            if (cur == term_of(v)) return 0;
            return (cur + 1) % 16;
        end
        return cur;
    endfunction

    function automatic string tag_of(int v, int cur, bit c, bit l, bit p, bit t);
        if (!c && (!l || (p && t))) return "R10";
        if (!c) return is_async(v) ? "R5" : "R6";
        if (!l) return (p && t) ? "R10" : "R2";
        if (p && t) begin
            if (cur == term_of(v)) return "R8";
            if (is_dec(v) && cur > 9) return "R9";
            return "R3";
        end
        return "R4";
    endfunction

    task automatic chk(string tag, int v, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s variant %0d %s: actual %0d expected %0d", tag, v, what, act, expv);
        end
    endtask

    task automatic cycle(bit c, bit l, int d, bit p, bit t);
        string tags [4];
        @(negedge clk);
        clr_n = c; load_n = l; din = 4'(d); en_p = p; en_t = t;
        #1;
        for (int v = 0; v < 4; v++) begin
            if (is_async(v) && !c) begin
                expq[v] = 0;
                chk("R5", v, "q after immediate clear", get_q(v), 0);
            end else begin
                chk("R1", v, "q between edges", get_q(v), expq[v]);
            end
            chk(is_dec(v) && expq[v] > 9 ? "R9" : "R7", v, "carry",
                get_c(v), int'(t && expq[v] == term_of(v)));
        end
        @(posedge clk);
        for (int v = 0; v < 4; v++) begin
            tags[v] = tag_of(v, expq[v], c, l, p, t);
            expq[v] = model_next(v, expq[v], c, l, d, p, t);
        end
        #1;
        for (int v = 0; v < 4; v++)
            chk(tags[v], v, "q after edge", get_q(v), expq[v]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        #1 clr_n = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        for (int v = 0; v < 4; v++) begin
            expq[v] = 0;
            chk(is_async(v) ? "R5" : "R6", v, "reset q", get_q(v), 0);
            chk("R7", v, "reset carry", get_c(v), 0);
        end
        // preset with enables low (R2), then count through the wrap (R3, R8)
        cycle(1, 0, 7, 0, 0);
        for (int i = 0; i < 6; i++) cycle(1, 1, 0, 1, 1);
        // one enable at a time inhibits (R4)
        cycle(1, 1, 0, 1, 0);
        cycle(1, 1, 0, 0, 1);
        // load ignores enables; carry follows en_t at 9 (R7)
        cycle(1, 0, 9, 1, 1);
        cycle(1, 1, 0, 0, 1);
        cycle(1, 1, 0, 0, 0);
        cycle(1, 1, 0, 1, 1);
        // out-of-range decade values run on and wrap at 15 (R9)
        cycle(1, 0, 14, 0, 0);
        for (int i = 0; i < 3; i++) cycle(1, 1, 0, 1, 1);
        cycle(1, 0, 15, 0, 1);
        cycle(1, 1, 0, 0, 1);
        // priority cases (R10)
        cycle(0, 0, 5, 1, 1);
        cycle(1, 0, 3, 1, 1);
        cycle(0, 1, 0, 1, 1);
        cycle(1, 1, 0, 1, 1);
        // random mix
        for (int i = 0; i < 800; i++) begin
            cycle(($urandom % 16) != 0, ($urandom % 8) != 0, int'($urandom % 16),
                  ($urandom % 4) != 0, ($urandom % 4) != 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule